// File: doc/BRIEF.md
# Front-Panel Mode and Service-Test Controller

This block is the front-panel brain of a surround audio processor. It receives single-cycle, already debounced pulses for four panel keys (power, input, effect, output), a level that says whether external supply is present, and a flag that says whether the current stream carries a rear-centre channel. From these it keeps the standby/active power state, the selected input source, the sound field and the output rendering mode. It drives one bit per indicator lamp and a handful of control bits (main-power request, source, field, output mode, tone enable, tone choice, channel mute mask) for the audio path.

A factory service mode is entered only by applying supply while the power and input keys are pressed together. It walks through a lamp check (a running light, then all lamps including the infrared emitter, then all dark), a key check that lights the lamp group of each key pressed, and a test-tone stage that selects one of four tones and cycles the channel muting. The service mode is left either by removing supply or by stepping past the last tone, which hands over to normal operation with default settings.

Top module: `panel_mode_ctrl`

## Requirements
- R1: After reset, and whenever supply is absent, every lamp is dark, powerOn is 0, testActive is 0, muteMask is 2'b11 and key pulses have no effect.
- R2: When supply appears without the service chord the block enters standby (lamps dark, powerOn 0, muteMask 2'b11); a lone POWER pulse toggles between standby and active, and in standby every other key is ignored. In active, powerOn is 1, muteMask is 2'b00 and the power lamp (bit 0) is lit.
- R3: In active, an INPUT pulse steps srcSel 0 (digital 1) to 1 (digital 2) to 2 (analog) and back to 0; exactly one of lamps bit 1, bit 2, bit 3 is lit, at index 1 + srcSel.
- R4: In active, an OUTPUT pulse steps outMode 0 (off) to 1 (virtual front) to 2 (virtual surround) and back to 0. Lamp bits: off lights headphone L/R (14, 15); front lights FL (7), FR (9) and VIRTUAL (13); surround additionally lights FC (8), SL (10) and SR (12), plus SC (11) only while backChan is 1.
- R5: In active, an EFFECT pulse steps fieldSel 0 (cinema 1) to 1 (cinema 2) to 2 (music) and back to 0, lamp at bit 4 + fieldSel, but only while outMode is not off; with outMode off it has no effect.
- R6: A cycle with two or more key pulses is ignored in standby, active and every service stage.
- R7: While supplyOk is low the block is back in the no-supply state after the next clock edge, from any state and regardless of keys in that cycle; the next application of supply starts from srcSel 0, outMode 0, fieldSel 0.
- R8: The service mode starts only when supply appears in a cycle whose key pulses are exactly POWER and INPUT; testActive and powerOn are then 1. Any other key set on that cycle gives standby.
- R9: On entry to the service mode exactly one lamp is lit, starting at bit 0 and moving to the next bit every STEP_CYCLES cycles, wrapping from bit 16 to bit 0.
- R10: During the lamp check, EFFECT moves running light to all 17 lamps lit (including infrared emitter, bit 16), then to all dark, then back to a restarted running light; POWER moves to the key check from any of the three.
- R11: In the key check lamps are dark until a key is pressed; INPUT lights bits 1..3, EFFECT bits 4..6, OUTPUT bits 7..15; POWER moves to the tone stage.
- R12: In the tone stage toneEn is 1 and toneSel starts at 0 (1 kHz 0 dBV; 1, 2, 3 are 1 kHz, 100 Hz, 10 kHz at -10 dBV). OUTPUT cycles muteMask 2'b00 (both), 2'b10 (right muted), 2'b01 (left muted); INPUT advances the tone and restores both channels. Lamps: bit 1 + toneSel, plus FL/HL for an audible left and FR/HR for an audible right.
- R13: INPUT at toneSel 3 leaves the service mode into active with srcSel 0, outMode 0, fieldSel 0; toneEn returns to 0. The service mode is never left any other way while supply is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supplyOk | input | 1 | External supply present (level) |
| keyPower | input | 1 | POWER key pulse |
| keyInput | input | 1 | INPUT key pulse |
| keyEffect | input | 1 | EFFECT key pulse |
| keyOutput | input | 1 | OUTPUT key pulse |
| backChan | input | 1 | Stream carries a rear-centre channel |
| ledOut | output | 17 | One bit per indicator lamp |
| powerOn | output | 1 | Main power request |
| testActive | output | 1 | Service mode running |
| srcSel | output | 2 | Selected input source |
| fieldSel | output | 2 | Selected sound field |
| outMode | output | 2 | Output rendering mode |
| toneEn | output | 1 | Test tone enabled |
| toneSel | output | 2 | Test tone choice |
| muteMask | output | 2 | Bit 1 mutes right, bit 0 mutes left |

## Verification
Two events can land on the same clock edge: a supply drop and a key pulse, and the appearance of supply together with a key set. The bench drives a supply drop in the very cycle of an INPUT pulse and expects the dark state with no trace of the key after reconnection, and it drives supply-on with the exact chord, with the chord plus EFFECT, and with no keys, judging the outcome from testActive, powerOn and the lamps one edge later. A long pseudo-random key sweep with mixed single and multiple pulses and a toggling backChan flag is compared each cycle against an arithmetic model of source, field and output mode.

// File: rtl/panel_pkg.sv
package panel_pkg;

  localparam int NUM_LEDS  = 17;
  localparam int NUM_KEYS  = 4;
  localparam int NUM_MODES = 3;   // sources, fields, outputs, channel sets
  localparam int NUM_TONES = 4;
  localparam int SEL_W     = 2;
  localparam int TONE_W    = $clog2(NUM_TONES);

  // key vector positions
  localparam int KEY_PWR = 0;
  localparam int KEY_IN  = 1;
  localparam int KEY_EFF = 2;
  localparam int KEY_OUT = 3;
  localparam logic [NUM_KEYS-1:0] SERVICE_CHORD = 4'b0011;

  // lamp positions
  localparam int LED_PWR  = 0;
  localparam int LED_D1   = 1;
  localparam int LED_C1   = 4;
  localparam int LED_FL   = 7;
  localparam int LED_FC   = 8;
  localparam int LED_FR   = 9;
  localparam int LED_SL   = 10;
  localparam int LED_SC   = 11;
  localparam int LED_SR   = 12;
  localparam int LED_VIRT = 13;
  localparam int LED_HL   = 14;
  localparam int LED_HR   = 15;

  localparam logic [SEL_W-1:0] OUT_OFF   = 2'd0;
  localparam logic [SEL_W-1:0] OUT_FRONT = 2'd1;
  localparam logic [SEL_W-1:0] OUT_SURR  = 2'd2;

  typedef enum logic [1:0] {PH_DARK, PH_STANDBY, PH_ACTIVE, PH_TEST} phase_e;
  typedef enum logic [2:0] {ST_WALK, ST_ALL_ON, ST_ALL_OFF, ST_KEYS, ST_TONE} stage_e;
  typedef enum logic [1:0] {KG_NONE, KG_INPUT, KG_EFFECT, KG_OUTPUT} keygrp_e;

  typedef struct packed {
    phase_e  phase;
    stage_e  stage;
    keygrp_e keyGrp;
    logic    stepSrc;
    logic    stepField;
    logic    stepOut;
    logic    stepTone;
    logic    stepChan;
    logic    loadDefaults;
    logic    restartTest;
  } strobe_t;

  function automatic logic [SEL_W-1:0] nextOf3(input logic [SEL_W-1:0] v);
    return (v == SEL_W'(NUM_MODES - 1)) ? '0 : v + SEL_W'(1);
  endfunction

endpackage

// File: rtl/panel_ctrl_fsm.sv
module panel_ctrl_fsm
  import panel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                supplyOk,
  input  logic [NUM_KEYS-1:0] keys,
  input  logic                outVirtual,
  input  logic                lastTone,
  output strobe_t             ctrl
);

  phase_e  phaseQ, phaseD;
  stage_e  stageQ, stageD;
  keygrp_e grpQ, grpD;
  logic    supplyPrevQ;

  logic single, pwrK, inK, effK, outK, supplyRise;

  assign single     = $onehot(keys);
  assign pwrK       = single & keys[KEY_PWR];
  assign inK        = single & keys[KEY_IN];
  assign effK       = single & keys[KEY_EFF];
  assign outK       = single & keys[KEY_OUT];
  assign supplyRise = supplyOk & ~supplyPrevQ;

  always_comb begin
    phaseD = phaseQ;
    stageD = stageQ;
    grpD   = grpQ;
    ctrl.stepSrc      = 1'b0;
    ctrl.stepField    = 1'b0;
    ctrl.stepOut      = 1'b0;
    ctrl.stepTone     = 1'b0;
    ctrl.stepChan     = 1'b0;
    ctrl.loadDefaults = 1'b0;
    ctrl.restartTest  = 1'b0;
    if (!supplyOk) begin
      phaseD = PH_DARK;
      ctrl.loadDefaults = 1'b1;
    end else begin
      case (phaseQ)
        PH_DARK: begin
          if (supplyRise) begin
            if (keys == SERVICE_CHORD) begin
              phaseD = PH_TEST;
              stageD = ST_WALK;
              grpD   = KG_NONE;
              ctrl.restartTest  = 1'b1;
              ctrl.loadDefaults = 1'b1;
            end else begin
              phaseD = PH_STANDBY;
            end
          end
        end
        PH_STANDBY: if (pwrK) phaseD = PH_ACTIVE;
        PH_ACTIVE: begin
          if (pwrK) phaseD = PH_STANDBY;
          ctrl.stepSrc   = inK;
          ctrl.stepOut   = outK;
          ctrl.stepField = effK & outVirtual;
        end
        PH_TEST: begin
          case (stageQ)
            ST_WALK, ST_ALL_ON, ST_ALL_OFF: begin
              if (pwrK) begin
                stageD = ST_KEYS;
                grpD   = KG_NONE;
              end else if (effK) begin
                if (stageQ == ST_WALK) stageD = ST_ALL_ON;
                else if (stageQ == ST_ALL_ON) stageD = ST_ALL_OFF;
                else begin
                  stageD = ST_WALK;
                  ctrl.restartTest = 1'b1;
                end
              end
            end
            ST_KEYS: begin
              if (pwrK) begin
                stageD = ST_TONE;
                ctrl.restartTest = 1'b1;
              end else if (inK)  grpD = KG_INPUT;
              else if (effK)     grpD = KG_EFFECT;
              else if (outK)     grpD = KG_OUTPUT;
            end
            ST_TONE: begin
              if (inK) begin
                if (lastTone) begin
                  phaseD = PH_ACTIVE;
                  ctrl.loadDefaults = 1'b1;
                end else begin
                  ctrl.stepTone = 1'b1;
                end
              end
              ctrl.stepChan = outK;
            end
            default: stageD = ST_WALK;
          endcase
        end
        default: phaseD = PH_DARK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseQ      <= PH_DARK;
      stageQ      <= ST_WALK;
      grpQ        <= KG_NONE;
      supplyPrevQ <= 1'b0;
    end else begin
      phaseQ      <= phaseD;
      stageQ      <= stageD;
      grpQ        <= grpD;
      supplyPrevQ <= supplyOk;
    end
  end

  assign ctrl.phase  = phaseQ;
  assign ctrl.stage  = stageQ;
  assign ctrl.keyGrp = grpQ;

  // R7: a missing supply always lands in the dark state one edge later
  assert_supply_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !supplyOk |=> phaseQ == PH_DARK);

  // R8: service mode is only ever entered on the exact chord
  assert_test_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phaseQ == PH_TEST) |-> ($past(keys) == SERVICE_CHORD && $past(phaseQ) == PH_DARK));

  // R13: service mode is left only by supply loss or from the tone stage
  assert_test_exit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phaseQ == PH_TEST) |-> (!$past(supplyOk) || $past(stageQ) == ST_TONE));

endmodule

// File: rtl/panel_state_dp.sv
module panel_state_dp
  import panel_pkg::*;
#(
  parameter int STEP_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             ctrl,
  input  logic                backChan,
  output logic                outVirtual,
  output logic                lastTone,
  output logic [NUM_LEDS-1:0] ledOut,
  output logic                powerOn,
  output logic                testActive,
  output logic [SEL_W-1:0]    srcSel,
  output logic [SEL_W-1:0]    fieldSel,
  output logic [SEL_W-1:0]    outMode,
  output logic                toneEn,
  output logic [TONE_W-1:0]   toneSel,
  output logic [1:0]          muteMask
);

  localparam int CNT_W = $clog2(STEP_CYCLES + 1);
  localparam int IDX_W = $clog2(NUM_LEDS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_LEDS - 1);

  logic [SEL_W-1:0]  srcQ, fieldQ, outQ, chanQ;
  logic [TONE_W-1:0] toneQ;
  logic [IDX_W-1:0]  walkIdxQ;
  logic [CNT_W-1:0]  walkCntQ;
  logic              walking;

  assign walking = (ctrl.phase == PH_TEST) && (ctrl.stage == ST_WALK) && !ctrl.restartTest;

  // user selections
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcQ   <= '0;
      fieldQ <= '0;
      outQ   <= OUT_OFF;
    end else if (ctrl.loadDefaults) begin
      srcQ   <= '0;
      fieldQ <= '0;
      outQ   <= OUT_OFF;
    end else begin
      if (ctrl.stepSrc)   srcQ   <= nextOf3(srcQ);
      if (ctrl.stepField) fieldQ <= nextOf3(fieldQ);
      if (ctrl.stepOut)   outQ   <= nextOf3(outQ);
    end
  end

  // service-mode counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toneQ    <= '0;
      chanQ    <= '0;
      walkIdxQ <= '0;
      walkCntQ <= '0;
    end else if (ctrl.restartTest) begin
      toneQ    <= '0;
      chanQ    <= '0;
      walkIdxQ <= '0;
      walkCntQ <= '0;
    end else begin
      if (ctrl.stepTone) begin
        toneQ <= toneQ + TONE_W'(1);
        chanQ <= '0;
      end else if (ctrl.stepChan) begin
        chanQ <= nextOf3(chanQ);
      end
      if (walking) begin
        if (walkCntQ == CNT_LAST) begin
          walkCntQ <= '0;
          walkIdxQ <= (walkIdxQ == IDX_LAST) ? '0 : walkIdxQ + IDX_W'(1);
        end else begin
          walkCntQ <= walkCntQ + CNT_W'(1);
        end
      end
    end
  end

  // channel set 0 = both, 1 = left only, 2 = right only
  logic leftOn, rightOn;
  assign leftOn  = (chanQ != 2'd2);
  assign rightOn = (chanQ != 2'd1);

  always_comb begin
    ledOut = '0;
    case (ctrl.phase)
      PH_ACTIVE: begin
        ledOut[LED_PWR] = 1'b1;
        for (int i = 0; i < NUM_MODES; i++) begin
          if (srcQ == SEL_W'(i))   ledOut[LED_D1 + i] = 1'b1;
          if (fieldQ == SEL_W'(i)) ledOut[LED_C1 + i] = 1'b1;
        end
        case (outQ)
          OUT_FRONT: begin
            ledOut[LED_FL] = 1'b1; ledOut[LED_FR] = 1'b1; ledOut[LED_VIRT] = 1'b1;
          end
          OUT_SURR: begin
            ledOut[LED_FL] = 1'b1; ledOut[LED_FR] = 1'b1; ledOut[LED_VIRT] = 1'b1;
            ledOut[LED_FC] = 1'b1; ledOut[LED_SL] = 1'b1; ledOut[LED_SR] = 1'b1;
            ledOut[LED_SC] = backChan;
          end
          default: begin
            ledOut[LED_HL] = 1'b1; ledOut[LED_HR] = 1'b1;
          end
        endcase
      end
      PH_TEST: begin
        case (ctrl.stage)
          ST_WALK: for (int i = 0; i < NUM_LEDS; i++) ledOut[i] = (walkIdxQ == IDX_W'(i));
          ST_ALL_ON: ledOut = '1;
          ST_KEYS: begin
            case (ctrl.keyGrp)
              KG_INPUT:  for (int i = 0; i < NUM_MODES; i++) ledOut[LED_D1 + i] = 1'b1;
              KG_EFFECT: for (int i = 0; i < NUM_MODES; i++) ledOut[LED_C1 + i] = 1'b1;
              KG_OUTPUT: for (int i = LED_FL; i <= LED_HR; i++) ledOut[i] = 1'b1;
              default: ledOut = '0;
            endcase
          end
          ST_TONE: begin
            for (int i = 0; i < NUM_TONES; i++) ledOut[LED_D1 + i] = (toneQ == TONE_W'(i));
            ledOut[LED_FL] = leftOn;  ledOut[LED_HL] = leftOn;
            ledOut[LED_FR] = rightOn; ledOut[LED_HR] = rightOn;
          end
          default: ledOut = '0;
        endcase
      end
      default: ledOut = '0;
    endcase
  end

  assign outVirtual = (outQ != OUT_OFF);
  assign lastTone   = (toneQ == TONE_W'(NUM_TONES - 1));
  assign powerOn    = (ctrl.phase == PH_ACTIVE) || (ctrl.phase == PH_TEST);
  assign testActive = (ctrl.phase == PH_TEST);
  assign toneEn     = testActive && (ctrl.stage == ST_TONE);
  assign toneSel    = toneQ;
  assign srcSel     = srcQ;
  assign fieldSel   = fieldQ;
  assign outMode    = outQ;

  always_comb begin
    if (ctrl.phase == PH_ACTIVE)      muteMask = 2'b00;
    else if (toneEn)                  muteMask = {~rightOn, ~leftOn};
    else                              muteMask = 2'b11;
  end

  // R5: the field changes only with a virtual mode in force (or on a default reload)
  assert_field_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fieldQ) |-> ($past(outQ) != OUT_OFF || $past(ctrl.loadDefaults)));

  // R3: exactly one source lamp in active operation
  assert_one_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.phase == PH_ACTIVE |-> $countones(ledOut[LED_D1 +: NUM_MODES]) == 1);

  // R9: running light shows one lamp and its index stays in range
  assert_walk_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.phase == PH_TEST && ctrl.stage == ST_WALK) |-> ($onehot(ledOut) && walkIdxQ <= IDX_LAST));

  // R12: a tone is never played with both channels muted
  assert_tone_mute_R12: assert property (@(posedge clk) disable iff (!rst_n)
    toneEn |-> muteMask != 2'b11);

endmodule

// File: rtl/panel_mode_ctrl.sv
module panel_mode_ctrl
  import panel_pkg::*;
#(
  parameter int STEP_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                supplyOk,
  input  logic                keyPower,
  input  logic                keyInput,
  input  logic                keyEffect,
  input  logic                keyOutput,
  input  logic                backChan,
  output logic [16:0]         ledOut,
  output logic                powerOn,
  output logic                testActive,
  output logic [1:0]          srcSel,
  output logic [1:0]          fieldSel,
  output logic [1:0]          outMode,
  output logic                toneEn,
  output logic [1:0]          toneSel,
  output logic [1:0]          muteMask
);

  strobe_t             ctrl;
  logic                outVirtual, lastTone;
  logic [NUM_KEYS-1:0] keys;

  assign keys = {keyOutput, keyEffect, keyInput, keyPower};

  panel_ctrl_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .supplyOk   (supplyOk),
    .keys       (keys),
    .outVirtual (outVirtual),
    .lastTone   (lastTone),
    .ctrl       (ctrl)
  );

  panel_state_dp #(.STEP_CYCLES(STEP_CYCLES)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .backChan   (backChan),
    .outVirtual (outVirtual),
    .lastTone   (lastTone),
    .ledOut     (ledOut),
    .powerOn    (powerOn),
    .testActive (testActive),
    .srcSel     (srcSel),
    .fieldSel   (fieldSel),
    .outMode    (outMode),
    .toneEn     (toneEn),
    .toneSel    (toneSel),
    .muteMask   (muteMask)
  );

endmodule

// File: tb/test_panel_mode_ctrl.sv
`timescale 1ns/1ps
module test_panel_mode_ctrl;

  localparam int STEP = 8;
  localparam logic [3:0] K_PWR = 4'b0001, K_IN = 4'b0010, K_EFF = 4'b0100, K_OUT = 4'b1000;

  logic clk = 1'b0, rst_n = 1'b0, supplyOk = 1'b0, backChan = 1'b0;
  logic [3:0] keys = 4'b0;
  logic [16:0] ledOut;
  logic powerOn, testActive, toneEn;
  logic [1:0] srcSel, fieldSel, outMode, toneSel, muteMask;

  int tests = 0, fails = 0;
  // bench model: 0 dark, 1 standby, 2 active
  int mPh = 0, mSrc = 0, mFld = 0, mOut = 0;

  always #10 clk = ~clk;

  panel_mode_ctrl #(.STEP_CYCLES(STEP)) i_panel_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .supplyOk(supplyOk),
    .keyPower(keys[0]), .keyInput(keys[1]), .keyEffect(keys[2]), .keyOutput(keys[3]),
    .backChan(backChan), .ledOut(ledOut), .powerOn(powerOn), .testActive(testActive),
    .srcSel(srcSel), .fieldSel(fieldSel), .outMode(outMode), .toneEn(toneEn),
    .toneSel(toneSel), .muteMask(muteMask));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] expLed(int ph, int src, int fld, int om, logic back);
    logic [16:0] e = '0;
    if (ph != 2) return e;
    e[0] = 1'b1; e[1 + src] = 1'b1; e[4 + fld] = 1'b1;
    case (om)
      0: begin e[14] = 1'b1; e[15] = 1'b1; end
      1: begin e[7] = 1'b1; e[9] = 1'b1; e[13] = 1'b1; end
      default: begin
        e[7] = 1'b1; e[8] = 1'b1; e[9] = 1'b1; e[10] = 1'b1; e[12] = 1'b1; e[13] = 1'b1;
        e[11] = back;
      end
    endcase
    return e;
  endfunction

  task automatic chkNormal(input string tag);
    chk({tag, " lamps"}, 32'(ledOut), 32'(expLed(mPh, mSrc, mFld, mOut, backChan)));
    chk({tag, " powerOn"}, 32'(powerOn), 32'(mPh == 2));
    chk({tag, " mute"}, 32'(muteMask), (mPh == 2) ? 32'd0 : 32'd3);
    chk({tag, " testActive"}, 32'(testActive), 32'd0);
    if (mPh == 2) begin
      chk({tag, " srcSel"}, 32'(srcSel), 32'(mSrc));
      chk({tag, " fieldSel"}, 32'(fieldSel), 32'(mFld));
      chk({tag, " outMode"}, 32'(outMode), 32'(mOut));
    end
  endtask

  // one-cycle key pulse; returns at the negedge after the capturing edge
  task automatic pulse(input logic [3:0] k);
    @(negedge clk); keys = k;
    @(negedge clk); keys = 4'b0;
  endtask

  task automatic modelKey(input logic [3:0] k);
    if ($countones(k) != 1) return;           // R6
    if (mPh == 1 && k[0]) mPh = 2;
    else if (mPh == 2) begin
      if (k[0]) mPh = 1;
      if (k[1]) mSrc = (mSrc + 1) % 3;
      if (k[3]) mOut = (mOut + 1) % 3;
      if (k[2] && mOut != 0) mFld = (mFld + 1) % 3;
    end
  endtask

  task automatic connect(input logic [3:0] k);
    @(negedge clk); supplyOk = 1'b1; keys = k;
    @(negedge clk); keys = 4'b0;
  endtask

  task automatic drop();
    @(negedge clk); supplyOk = 1'b0;
    @(negedge clk);
    mPh = 0; mSrc = 0; mFld = 0; mOut = 0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkNormal("R1 reset");
    pulse(K_PWR);
    chkNormal("R1 key ignored without supply");

    // plain connect -> standby, keys other than POWER ignored
    connect(4'b0);
    mPh = 1;
    chkNormal("R2 standby after connect");
    pulse(K_IN); pulse(K_OUT);
    chkNormal("R2 standby ignores keys");
    pulse(K_PWR); modelKey(K_PWR);
    chkNormal("R2 active after POWER");

    // source cycle
    for (int i = 0; i < 4; i++) begin
      pulse(K_IN); modelKey(K_IN);
      chkNormal("R3 source step");
    end
    // effect ignored in off
    pulse(K_EFF); modelKey(K_EFF);
    chkNormal("R5 effect ignored in off");
    chk("R5 field stays 0", 32'(fieldSel), 32'd0);
    // output cycle with and without back channel
    for (int i = 0; i < 4; i++) begin
      pulse(K_OUT); modelKey(K_OUT);
      chkNormal("R4 output step");
      pulse(K_EFF); modelKey(K_EFF);
      chkNormal("R5 effect step");
    end
    pulse(K_OUT); modelKey(K_OUT);
    backChan = 1'b1; @(negedge clk);
    chkNormal("R4 surround with back channel");
    pulse(K_IN | K_OUT);
    chkNormal("R6 double press ignored");

    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int s = 0; s < 400; s++) begin
      logic [3:0] k;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      k = (lfsr[7:6] != 2'b00) ? (4'b0001 << lfsr[1:0]) : lfsr[3:0];
      backChan = lfsr[8];
      pulse(k); modelKey(k);
      chkNormal("R4 R5 R6 sweep");
    end

    // make sure active with non-default state, then drop in same cycle as a key
    if (mPh != 2) begin pulse(K_PWR); modelKey(K_PWR); end
    pulse(K_IN); modelKey(K_IN);
    @(negedge clk); supplyOk = 1'b0; keys = K_IN;
    @(negedge clk); keys = 4'b0;
    mPh = 0; mSrc = 0; mFld = 0; mOut = 0;
    chkNormal("R7 drop wins over key");
    connect(4'b0); mPh = 1;
    pulse(K_PWR); modelKey(K_PWR);
    chkNormal("R7 defaults after reconnect");
    chk("R7 source default", 32'(srcSel), 32'd0);

    // chord plus extra key -> standby
    drop();
    connect(K_PWR | K_IN | K_EFF); mPh = 1;
    chkNormal("R8 impure chord gives standby");

    // service mode: entry and running light
    drop();
    connect(K_PWR | K_IN);
    chk("R8 testActive", 32'(testActive), 32'd1);
    chk("R8 powerOn", 32'(powerOn), 32'd1);
    chk("R9 first lamp", 32'(ledOut), 32'h1);
    repeat (STEP - 1) @(negedge clk);
    chk("R9 still first lamp", 32'(ledOut), 32'h1);
    for (int s = 1; s <= 17; s++) begin
      if (s == 1) @(negedge clk); else repeat (STEP) @(negedge clk);
      chk("R9 walk step", 32'(ledOut), 32'(17'h1 << (s % 17)));
    end
    pulse(K_EFF);
    chk("R10 all on incl emitter", 32'(ledOut), 32'h1FFFF);
    pulse(K_EFF);
    chk("R10 all off", 32'(ledOut), 32'h0);
    pulse(K_EFF);
    chk("R10 walk restarted", 32'(ledOut), 32'h1);
    pulse(K_PWR);
    chk("R10 key check dark", 32'(ledOut), 32'h0);
    chk("R11 testActive kept", 32'(testActive), 32'd1);
    pulse(K_IN);
    chk("R11 input group", 32'(ledOut), 32'h0000E);
    pulse(K_EFF);
    chk("R11 effect group", 32'(ledOut), 32'h00070);
    pulse(K_OUT);
    chk("R11 output group", 32'(ledOut), 32'h0FF80);
    pulse(K_IN | K_EFF);
    chk("R6 test double press", 32'(ledOut), 32'h0FF80);
    pulse(K_PWR);
    chk("R12 toneEn", 32'(toneEn), 32'd1);
    chk("R12 tone 0", 32'(toneSel), 32'd0);
    chk("R12 both audible", 32'(muteMask), 32'd0);
    chk("R12 tone lamps", 32'(ledOut), 32'h0C282);
    pulse(K_OUT);
    chk("R12 right muted", 32'(muteMask), 32'd2);
    chk("R12 left-only lamps", 32'(ledOut), 32'h04082);
    pulse(K_OUT);
    chk("R12 left muted", 32'(muteMask), 32'd1);
    chk("R12 right-only lamps", 32'(ledOut), 32'h08202);
    pulse(K_OUT);
    chk("R12 both again", 32'(muteMask), 32'd0);
    pulse(K_OUT);
    for (int t = 1; t < 4; t++) begin
      pulse(K_IN);
      chk("R12 tone step", 32'(toneSel), 32'(t));
      chk("R12 channels restored", 32'(muteMask), 32'd0);
      chk("R12 tone lamp", 32'(ledOut), 32'(17'h0C280 | (17'h2 << t)));
    end
    pulse(K_IN);
    mPh = 2; mSrc = 0; mFld = 0; mOut = 0;
    chk("R13 toneEn off", 32'(toneEn), 32'd0);
    chkNormal("R13 back to active defaults");

    // drop during service mode
    drop();
    connect(K_PWR | K_IN);
    chk("R8 re-entry", 32'(testActive), 32'd1);
    drop();
    chkNormal("R7 test left by drop");
    connect(4'b0); mPh = 1;
    chkNormal("R2 standby after test drop");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule